// File: doc/BRIEF.md
# Integer Register File with Fixed-Target Write Requests

This block stores the 32 integer registers of a RISC-style core. Two independent read ports return register contents combinationally, and one general write port stores a value at an indexed register on the rising clock edge. Register 0 is not storage: it always reads as zero, and writes aimed at it are lost.

Three extra write-request inputs let specific instruction classes deposit a result without supplying a register index. An add-immediate-left result always lands in register 1. A call-and-link return address lands in register 31. A second call-and-link form, which exists only in the wide configuration, lands in register 2. A single parameter selects between a 32-bit narrow configuration and a 64-bit wide configuration. When a fixed-target request and the general port hit the same register in the same cycle, the fixed-target request is the one stored, and a one-cycle collision pulse is raised.

Decode, arithmetic and forwarding belong to other blocks. This block keeps only the storage, decides which write wins, and drives the read ports.

Top module: `gp_regfile`

## Requirements
- R1: There are 32 registers addressed by a 5-bit index. When `wr_en` is high at a rising edge, `wr_data` is stored in register `wr_idx`.
- R2: Registers and data ports are 64 bits wide when parameter `WIDE` is 1, and 32 bits wide when `WIDE` is 0.
- R3: Reading index 0 on either port returns zero. A general write to index 0 changes nothing.
- R4: When `addil_we` is high at a rising edge, `addil_data` is stored in register 1.
- R5: When `bl_we` is high at a rising edge, `bl_data` is stored in register 31.
- R6: When `WIDE` is 1 and `vbl_we` is high at a rising edge, `vbl_data` is stored in register 2. When `WIDE` is 0, `vbl_we` and `vbl_data` have no effect on any register or on `conflict`.
- R7: If a general write and an active fixed-target request name the same register in one cycle, the register takes the fixed-target data. In the following cycle `conflict` is 1 for exactly one cycle. Otherwise `conflict` is 0.
- R8: The read data on both ports follows the index combinationally. During a cycle that writes the register being read, the port shows the value held before the edge, with no bypass.
- R9: When `rst_n` is low at a rising edge, every register and `conflict` become 0.
- R10: Fixed-target requests to different registers in the same cycle all take effect, together with a general write to any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 5 | General write register index |
| wr_data | input | XLEN | General write data |
| addil_we | input | 1 | Add-immediate-left result request (register 1) |
| addil_data | input | XLEN | Add-immediate-left result |
| bl_we | input | 1 | Call-and-link request (register 31) |
| bl_data | input | XLEN | Return address for register 31 |
| vbl_we | input | 1 | Wide call-and-link request (register 2, wide configuration only) |
| vbl_data | input | XLEN | Return address for register 2 |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | XLEN | Read port B data |
| conflict | output | 1 | One-cycle pulse after a same-register write collision |

## Verification
Both configurations run side by side on the same stimulus, so the narrow copy shows that the wide-only request changes nothing while the wide copy stores it. Every index is written and read back through both ports with distinct patterns. A swapped or off-by-one decode would show up as a misplaced value, and a zero register that stores data would read nonzero. Collisions are driven on each fixed target and also next to it: a design that let the general port win would show the explicit data, a flag that stays high would still read 1 one cycle later, and a narrow copy that flags register 2 would pulse when it should not. Reads taken during a same-register write expose any bypass, which would show the new value too early.

// File: rtl/gpr_pkg.sv
// Shared constants for the integer register file.
// Assumes a fixed 32-entry file; only the data width varies.
package gpr_pkg;
    localparam int unsigned GPR_COUNT = 32;
    localparam int unsigned GPR_IDX_W = $clog2(GPR_COUNT);

    // Fixed destinations of the index-free write requests.
    localparam int unsigned IDX_ADDIL = 1;
    localparam int unsigned IDX_VLINK = 2;
    localparam int unsigned IDX_LINK  = 31;

    // Data width for the chosen configuration.
    function automatic int unsigned xlen_of(input bit wide);
        return wide ? 64 : 32;
    endfunction
endpackage

// File: rtl/gpr_write_arbiter.sv
// Turns the general write port and the fixed-target requests into a
// per-register enable and data vector, and registers the collision pulse.
// Assumes index 0 is never stored; the wide-only request is masked when WIDE=0.
module gpr_write_arbiter
    import gpr_pkg::*;
#(
    parameter bit          WIDE = 1'b1,
    parameter int unsigned XLEN = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [GPR_IDX_W-1:0]                wr_idx,
    input  logic [XLEN-1:0]                     wr_data,
    input  logic                                addil_we,
    input  logic [XLEN-1:0]                     addil_data,
    input  logic                                bl_we,
    input  logic [XLEN-1:0]                     bl_data,
    input  logic                                vbl_we,
    input  logic [XLEN-1:0]                     vbl_data,
    output logic [GPR_COUNT-1:0]                we_vec,
    output logic [GPR_COUNT-1:0][XLEN-1:0]      wdata_vec,
    output logic                                conflict
);
    localparam logic [GPR_IDX_W-1:0] ADDIL_I = GPR_IDX_W'(IDX_ADDIL);
    localparam logic [GPR_IDX_W-1:0] LINK_I  = GPR_IDX_W'(IDX_LINK);
    localparam logic [GPR_IDX_W-1:0] VLINK_I = GPR_IDX_W'(IDX_VLINK);

    logic vbl_eff;
    logic clash;

    // The wide-only request exists only in the wide configuration.
    assign vbl_eff = WIDE & vbl_we;

    // Build the write vector: general port first, fixed targets override it.
    always_comb begin
        for (int i = 0; i < GPR_COUNT; i++) begin
            we_vec[i]    = 1'b0;
            wdata_vec[i] = wr_data;
        end
        if (wr_en && (wr_idx != '0)) begin
            we_vec[wr_idx] = 1'b1;
        end
        if (addil_we) begin
            we_vec[IDX_ADDIL]    = 1'b1;
            wdata_vec[IDX_ADDIL] = addil_data;
        end
        if (bl_we) begin
            we_vec[IDX_LINK]    = 1'b1;
            wdata_vec[IDX_LINK] = bl_data;
        end
        if (vbl_eff) begin
            we_vec[IDX_VLINK]    = 1'b1;
            wdata_vec[IDX_VLINK] = vbl_data;
        end
    end

    // Detect a general write that lands on an active fixed target.
    assign clash = wr_en && ((addil_we && (wr_idx == ADDIL_I)) ||
                             (bl_we    && (wr_idx == LINK_I))  ||
                             (vbl_eff  && (wr_idx == VLINK_I)));

    // Register the collision so it pulses in the cycle after the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) conflict <= 1'b0;
        else        conflict <= clash;
    end

    assert_clash_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bl_we && (wr_idx == LINK_I)) |=> conflict);

    assert_flag_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> !conflict);
endmodule

// File: rtl/gpr_storage.sv
// Flop storage for registers 1..31; register 0 is a constant zero.
// Assumes the enable vector already resolves all write priorities.
module gpr_storage
    import gpr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [GPR_COUNT-1:0]           we_vec,
    input  logic [GPR_COUNT-1:0][XLEN-1:0] wdata_vec,
    output logic [GPR_COUNT-1:0][XLEN-1:0] q
);
    // Register 0 holds nothing; its write lane is deliberately dropped.
    logic unused_zero_lane;
    assign unused_zero_lane = we_vec[0] ^ (^wdata_vec[0]);
    assign q[0] = '0;

    for (genvar g = 1; g < GPR_COUNT; g++) begin : g_reg
        // One register: clear on reset, load on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[g] <= '0;
            else if (we_vec[g]) q[g] <= wdata_vec[g];
        end
    end
endmodule

// File: rtl/gpr_read_port.sv
// One combinational read port. Assumes entry 0 of the array is zero,
// and forces zero for index 0 regardless.
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [GPR_COUNT-1:0][XLEN-1:0] q,
    input  logic [GPR_IDX_W-1:0]           idx,
    output logic [XLEN-1:0]                data
);
    // Select the addressed register without any write bypass.
    always_comb begin
        if (idx == '0) data = '0;
        else           data = q[idx];
    end
endmodule

// File: rtl/gp_regfile.sv
// Top of the integer register file: arbiter, storage and two read ports.
// Assumes one general write and up to three fixed-target requests per cycle.
module gp_regfile
    import gpr_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    localparam int unsigned XLEN = xlen_of(WIDE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [4:0]           wr_idx,
    input  logic [XLEN-1:0]      wr_data,
    input  logic                 addil_we,
    input  logic [XLEN-1:0]      addil_data,
    input  logic                 bl_we,
    input  logic [XLEN-1:0]      bl_data,
    input  logic                 vbl_we,
    input  logic [XLEN-1:0]      vbl_data,
    input  logic [4:0]           rd_a_idx,
    output logic [XLEN-1:0]      rd_a_data,
    input  logic [4:0]           rd_b_idx,
    output logic [XLEN-1:0]      rd_b_data,
    output logic                 conflict
);
    localparam int unsigned NREAD = 2;

    logic [GPR_COUNT-1:0]           we_vec;
    logic [GPR_COUNT-1:0][XLEN-1:0] wdata_vec;
    logic [GPR_COUNT-1:0][XLEN-1:0] gpr_q;
    logic [NREAD-1:0][4:0]          rd_idx;
    logic [NREAD-1:0][XLEN-1:0]     rd_data;

    gpr_write_arbiter #(.WIDE(WIDE), .XLEN(XLEN)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .addil_we   (addil_we),
        .addil_data (addil_data),
        .bl_we      (bl_we),
        .bl_data    (bl_data),
        .vbl_we     (vbl_we),
        .vbl_data   (vbl_data),
        .we_vec     (we_vec),
        .wdata_vec  (wdata_vec),
        .conflict   (conflict)
    );

    gpr_storage #(.XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_vec    (we_vec),
        .wdata_vec (wdata_vec),
        .q         (gpr_q)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        gpr_read_port #(.XLEN(XLEN)) u_rd (
            .q    (gpr_q),
            .idx  (rd_idx[p]),
            .data (rd_data[p])
        );
    end

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    assert_zero_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    assert_addil_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addil_we |=> (gpr_q[1] == $past(addil_data)));

    assert_link_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bl_we |=> (gpr_q[31] == $past(bl_data)));

    if (WIDE) begin : g_chk_wide
        assert_vlink_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
            vbl_we |=> (gpr_q[2] == $past(vbl_data)));
    end else begin : g_chk_narrow
        assert_vlink_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (vbl_we && !(wr_en && (wr_idx == 5'd2))) |=> $stable(gpr_q[2]));
    end
endmodule

// File: tb/test_gp_regfile.sv
`timescale 1ns/1ps
module test_gp_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        addil_we = 1'b0;
    logic [63:0] addil_data = '0;
    logic        bl_we = 1'b0;
    logic [63:0] bl_data = '0;
    logic        vbl_we = 1'b0;
    logic [63:0] vbl_data = '0;
    logic [4:0]  rd_a_idx = '0;
    logic [4:0]  rd_b_idx = '0;
    logic [63:0] rdw_a, rdw_b;
    logic [31:0] rdn_a, rdn_b;
    logic        cflw, cfln;

    int total = 0;
    int bad = 0;
    logic [63:0] mw [32];
    logic [31:0] mn [32];

    always #2.5 clk = ~clk;

    gp_regfile #(.WIDE(1'b1)) i_gp_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .addil_we(addil_we), .addil_data(addil_data), .bl_we(bl_we), .bl_data(bl_data),
        .vbl_we(vbl_we), .vbl_data(vbl_data), .rd_a_idx(rd_a_idx), .rd_a_data(rdw_a),
        .rd_b_idx(rd_b_idx), .rd_b_data(rdw_b), .conflict(cflw)
    );

    gp_regfile #(.WIDE(1'b0)) i_gp_regfile_n (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data[31:0]),
        .addil_we(addil_we), .addil_data(addil_data[31:0]), .bl_we(bl_we), .bl_data(bl_data[31:0]),
        .vbl_we(vbl_we), .vbl_data(vbl_data[31:0]), .rd_a_idx(rd_a_idx), .rd_a_data(rdn_a),
        .rd_b_idx(rd_b_idx), .rd_b_data(rdn_b), .conflict(cfln)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i, input int salt);
        return {32'hC0DE0000 + 32'(salt * 256) + 32'(i),
                32'h13570000 ^ (32'(i) * 32'h01010101) ^ 32'(salt)};
    endfunction

    task automatic idle();
        wr_en = 1'b0; addil_we = 1'b0; bl_we = 1'b0; vbl_we = 1'b0;
    endtask

    // One clock: update the model after the edge, then check the collision flags.
    task automatic step(input string req);
        logic cw, cn;
        cn = rst_n && wr_en && ((addil_we && wr_idx == 5'd1) || (bl_we && wr_idx == 5'd31));
        cw = cn || (rst_n && wr_en && vbl_we && wr_idx == 5'd2);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin mw[i] = '0; mn[i] = '0; end
        end else begin
            if (wr_en && wr_idx != 5'd0) begin
                mw[wr_idx] = wr_data; mn[wr_idx] = wr_data[31:0];
            end
            if (addil_we) begin mw[1] = addil_data; mn[1] = addil_data[31:0]; end
            if (bl_we) begin mw[31] = bl_data; mn[31] = bl_data[31:0]; end
            if (vbl_we) mw[2] = vbl_data;
        end
        idle();
        chk({req, " conflict wide"}, {63'd0, cflw}, {63'd0, cw});
        chk({req, " conflict narrow"}, {63'd0, cfln}, {63'd0, cn});
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            #0.5;
            chk({req, " wide A"}, rdw_a, mw[i]);
            chk({req, " wide B"}, rdw_b, mw[31 - i]);
            chk({req, " narrow A"}, {32'd0, rdn_a}, {32'd0, mn[i]});
            chk({req, " narrow B"}, {32'd0, rdn_b}, {32'd0, mn[31 - i]});
        end
    endtask

    initial begin
        #(200000.0 * 5.0);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin mw[i] = '0; mn[i] = '0; end
        // R9: reset clears everything
        rst_n = 1'b0;
        step("R9 reset");
        step("R9 reset");
        read_all("R9 after reset");
        rst_n = 1'b1;

        // R1 / R2 / R3: write every index, including 0, then read all
        for (int i = 0; i < 32; i++) begin
            wr_en = 1'b1; wr_idx = 5'(i); wr_data = pat(i, 1);
            step("R1 sweep");
        end
        read_all("R1/R2/R3 sweep");

        // R8: during a same-register write the old value is seen
        for (int i = 3; i < 32; i += 7) begin
            wr_en = 1'b1; wr_idx = 5'(i); wr_data = pat(i, 9);
            rd_a_idx = 5'(i);
            #0.5;
            chk("R8 no bypass wide", rdw_a, mw[i]);
            chk("R8 no bypass narrow", {32'd0, rdn_a}, {32'd0, mn[i]});
            step("R8 write");
            chk("R8 after edge", rdw_a, pat(i, 9));
        end

        // R4, R5, R6 individually
        addil_we = 1'b1; addil_data = pat(1, 20);
        step("R4 addil");
        bl_we = 1'b1; bl_data = pat(31, 21);
        step("R5 link");
        vbl_we = 1'b1; vbl_data = pat(2, 22);
        step("R6 vlink");
        read_all("R4/R5/R6 fixed targets");

        // R10: all three plus a general write elsewhere
        addil_we = 1'b1; addil_data = pat(1, 30);
        bl_we = 1'b1; bl_data = pat(31, 31);
        vbl_we = 1'b1; vbl_data = pat(2, 32);
        wr_en = 1'b1; wr_idx = 5'd5; wr_data = pat(5, 33);
        step("R10 together");
        read_all("R10 together");

        // R7: collisions on each fixed target, then a quiet cycle
        wr_en = 1'b1; wr_idx = 5'd1; wr_data = pat(1, 40);
        addil_we = 1'b1; addil_data = pat(1, 41);
        step("R7 clash r1");
        step("R7 pulse ends");
        wr_en = 1'b1; wr_idx = 5'd31; wr_data = pat(31, 42);
        bl_we = 1'b1; bl_data = pat(31, 43);
        step("R7 clash r31");
        step("R7 pulse ends");
        wr_en = 1'b1; wr_idx = 5'd2; wr_data = pat(2, 44);
        vbl_we = 1'b1; vbl_data = pat(2, 45);
        step("R7/R6 clash r2");
        step("R7 pulse ends");
        wr_en = 1'b1; wr_idx = 5'd2; wr_data = pat(2, 46);
        addil_we = 1'b1; addil_data = pat(1, 47);
        step("R7 neighbour no clash");
        wr_en = 1'b1; wr_idx = 5'd0; wr_data = pat(0, 48);
        step("R3 write zero");
        read_all("R7 collision results");

        // R9: reset in mid-run with a request pending
        rst_n = 1'b0;
        wr_en = 1'b1; wr_idx = 5'd9; wr_data = pat(9, 50);
        step("R9 mid reset");
        rst_n = 1'b1;
        read_all("R9 mid reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule